// File: doc/BRIEF.md
# Masked Interrupt Priority Encoder

This block keeps two 32-bit registers: one records which interrupt sources are raised, the other says which of them may reach the processor. Sources raise and drop their own status bits through per-bit request inputs, and software can read either register or replace it in a single write. The block ANDs the two registers and reports, through a registered three-bit output, the highest processor priority level (1 to 7) that has an unmasked pending source. It reports 0 when no such source exists.

Each level owns a group of status bits, and the groups are set by parameters. A separate control input can raise one timer bit to the top level. A coprocessor request has two status bits, one in the level-3 group and one in the level-4 group. A select input, or a fixed variant strap, chooses which of the two bits it uses. When that choice changes while the request is pending, the pending request moves to the bit now selected. The processor's acknowledge cycle is handled elsewhere.

Top module: `irq_level_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, the status register, the mask register and `level_o` are all zero.
- R2: A write with `reg_sel_i`=0 replaces the whole status register, and a write with `reg_sel_i`=1 replaces the whole mask register. `reg_rdata_o` shows the register that `reg_sel_i` selects, with no delay.
- R3: An edge with `set_i[k]`=1 sets status bit k, and an edge with `clr_i[k]`=1 clears it. If both are 1 on the same edge, set wins. Request inputs act after a software write on the same edge.
- R4: `level_o` is 0 when status AND mask is zero.
- R5: Otherwise `level_o` is the highest level whose group has an effective pending bit. The default groups are: level 7 bits 31:30, level 6 bits 29:26, level 5 bits 25:22, level 4 bits 21:16, level 3 bits 15:8, level 2 bits 7:2, level 1 bits 1:0.
- R6: When `timer_top_i`=1 and timer bit 29 is effectively pending, `level_o` is 7. When `timer_top_i`=0, that bit counts only at level 6.
- R7: `level_o` is registered. It changes on the edge after the edge that changes status, mask or `timer_top_i`.
- R8: `cop_set_i` sets status bit 16 (level 4) when `cop_hi_sel_i` OR `variant_i` is 1, and sets bit 8 (level 3) otherwise. `cop_clr_i` clears both bits.
- R9: When the effective coprocessor select differs from its value on the previous edge and bit 8 or bit 16 is pending, both bits are cleared and the bit of the new selection is set. When neither bit is pending, a change of select leaves both bits clear.
- R10: The mask does not change status contents. Masked bits stay pending and can be read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 status, 1 mask |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| set_i | input | 32 | Per-source raise requests |
| clr_i | input | 32 | Per-source release requests |
| cop_set_i | input | 1 | Raise the coprocessor request |
| cop_clr_i | input | 1 | Release the coprocessor request |
| cop_hi_sel_i | input | 1 | Route the coprocessor to level 4 when 1 |
| variant_i | input | 1 | Strap that forces level-4 routing |
| timer_top_i | input | 1 | Raise the timer bit to level 7 |
| level_o | output | 3 | Current interrupt priority level |

## Verification
Three sweeps exercise the encoder. The first walks a single status bit through all 32 positions with every source unmasked, which pins down the group each bit belongs to. The second fills the status register and walks a single mask bit, which shows that the mask, not the status, decides what counts. The third sets every pair of bits, which checks that the higher group always wins. The timer bit is tried with promotion on and off. The coprocessor sequence toggles the select while a request is pending and again while it is idle, and then repeats with the strap set. This tells a real move apart from a spurious raise.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
  localparam int unsigned LVL_W   = 3;
  localparam int unsigned NUM_LVL = 1 << LVL_W;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_stat_regs.sv
module irq_stat_regs #(
  parameter int unsigned SRC_W      = 32,
  parameter int unsigned COP_LO_BIT = 8,
  parameter int unsigned COP_HI_BIT = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_stat_i,
  input  logic             wr_mask_i,
  input  logic [SRC_W-1:0] wdata_i,
  input  logic [SRC_W-1:0] set_i,
  input  logic [SRC_W-1:0] clr_i,
  input  logic             cop_set_i,
  input  logic             cop_clr_i,
  input  logic             cop_hi_i,
  output logic [SRC_W-1:0] stat_o,
  output logic [SRC_W-1:0] mask_o
);
  logic [SRC_W-1:0] stat_q, stat_d, mask_q;
  logic             sel_q;
  logic             cop_pend;

  always_comb begin
    stat_d   = wr_stat_i ? wdata_i : stat_q;
    cop_pend = stat_d[COP_LO_BIT] | stat_d[COP_HI_BIT];
    // move a pending coprocessor request to the newly selected level
    if ((cop_hi_i != sel_q) && cop_pend) begin
      stat_d[COP_LO_BIT] = 1'b0;
      stat_d[COP_HI_BIT] = 1'b0;
      if (cop_hi_i) stat_d[COP_HI_BIT] = 1'b1;
      else          stat_d[COP_LO_BIT] = 1'b1;
    end
    if (cop_clr_i) begin
      stat_d[COP_LO_BIT] = 1'b0;
      stat_d[COP_HI_BIT] = 1'b0;
    end
    if (cop_set_i) begin
      if (cop_hi_i) stat_d[COP_HI_BIT] = 1'b1;
      else          stat_d[COP_LO_BIT] = 1'b1;
    end
    stat_d = (stat_d & ~clr_i) | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '0;
      sel_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      sel_q  <= cop_hi_i;
      if (wr_mask_i) mask_q <= wdata_i;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_lvl_pkg::*;
#(
  parameter int unsigned                         SRC_W     = 32,
  parameter logic [NUM_LVL-1:0][SRC_W-1:0]       GRP_MASK  = '0,
  parameter int unsigned                         TIMER_BIT = 29
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_W-1:0] eff_i,
  input  logic             timer_top_i,
  output lvl_t             lvl_o
);
  logic [NUM_LVL-1:1] hit;
  lvl_t               lvl_d, lvl_q;

  for (genvar l = 1; l < NUM_LVL; l++) begin : g_grp
    assign hit[l] = |(eff_i & GRP_MASK[l]);
  end

  always_comb begin
    lvl_d = '0;
    for (int l = 1; l < NUM_LVL; l++) begin
      if (hit[l]) lvl_d = lvl_t'(l);
    end
    if (timer_top_i && eff_i[TIMER_BIT]) lvl_d = lvl_t'(NUM_LVL - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_d;
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_lvl_pkg::*;
#(
  parameter int unsigned                   SRC_W      = 32,
  parameter logic [NUM_LVL-1:0][SRC_W-1:0] GRP_MASK   = {32'hC000_0000, 32'h3C00_0000,
                                                         32'h03C0_0000, 32'h003F_0000,
                                                         32'h0000_FF00, 32'h0000_00FC,
                                                         32'h0000_0003, 32'h0000_0000},
  parameter int unsigned                   TIMER_BIT  = 29,
  parameter int unsigned                   COP_LO_BIT = 8,
  parameter int unsigned                   COP_HI_BIT = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic             reg_sel_i,
  input  logic [SRC_W-1:0] reg_wdata_i,
  output logic [SRC_W-1:0] reg_rdata_o,
  input  logic [SRC_W-1:0] set_i,
  input  logic [SRC_W-1:0] clr_i,
  input  logic             cop_set_i,
  input  logic             cop_clr_i,
  input  logic             cop_hi_sel_i,
  input  logic             variant_i,
  input  logic             timer_top_i,
  output logic [LVL_W-1:0] level_o
);
  logic [SRC_W-1:0] stat_w, mask_w;
  logic             cop_hi;

  assign cop_hi = cop_hi_sel_i | variant_i;

  irq_stat_regs #(
    .SRC_W     (SRC_W),
    .COP_LO_BIT(COP_LO_BIT),
    .COP_HI_BIT(COP_HI_BIT)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_stat_i(reg_we_i & ~reg_sel_i),
    .wr_mask_i(reg_we_i & reg_sel_i),
    .wdata_i  (reg_wdata_i),
    .set_i    (set_i),
    .clr_i    (clr_i),
    .cop_set_i(cop_set_i),
    .cop_clr_i(cop_clr_i),
    .cop_hi_i (cop_hi),
    .stat_o   (stat_w),
    .mask_o   (mask_w)
  );

  irq_prio_enc #(
    .SRC_W    (SRC_W),
    .GRP_MASK (GRP_MASK),
    .TIMER_BIT(TIMER_BIT)
  ) u_enc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .eff_i      (stat_w & mask_w),
    .timer_top_i(timer_top_i),
    .lvl_o      (level_o)
  );

  assign reg_rdata_o = reg_sel_i ? mask_w : stat_w;
endmodule

// File: rtl/irq_level_chk.sv
module irq_level_chk #(
  parameter int unsigned SRC_W      = 32,
  parameter logic [SRC_W-1:0] TOP_MASK = 32'hC000_0000,
  parameter int unsigned TIMER_BIT  = 29,
  parameter int unsigned COP_LO_BIT = 8,
  parameter int unsigned COP_HI_BIT = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic             reg_sel_i,
  input logic [SRC_W-1:0] reg_wdata_i,
  input logic [SRC_W-1:0] set_i,
  input logic [SRC_W-1:0] clr_i,
  input logic             cop_set_i,
  input logic             cop_clr_i,
  input logic             timer_top_i,
  input logic [SRC_W-1:0] stat_w,
  input logic [SRC_W-1:0] mask_w,
  input logic [2:0]       level_o
);
  // R2
  mask_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i) |=> (mask_w == $past(reg_wdata_i)));

  // R3
  set_sticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((stat_w & $past(set_i)) == $past(set_i)));

  // R4
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_w & mask_w) == '0) |=> (level_o == 3'd0));

  // R5
  top_group_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_w & mask_w & TOP_MASK) != '0) |=> (level_o == 3'd7));

  // R6
  timer_promo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timer_top_i && stat_w[TIMER_BIT] && mask_w[TIMER_BIT]) |=> (level_o == 3'd7));

  // R8
  cop_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cop_set_i && !cop_clr_i && !reg_we_i && clr_i[COP_LO_BIT] == 1'b0
     && clr_i[COP_HI_BIT] == 1'b0) |=> (stat_w[COP_LO_BIT] || stat_w[COP_HI_BIT]));
endmodule

bind irq_level_ctrl irq_level_chk #(
  .SRC_W     (SRC_W),
  .TOP_MASK  (GRP_MASK[7]),
  .TIMER_BIT (TIMER_BIT),
  .COP_LO_BIT(COP_LO_BIT),
  .COP_HI_BIT(COP_HI_BIT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_sel_i  (reg_sel_i),
  .reg_wdata_i(reg_wdata_i),
  .set_i      (set_i),
  .clr_i      (clr_i),
  .cop_set_i  (cop_set_i),
  .cop_clr_i  (cop_clr_i),
  .timer_top_i(timer_top_i),
  .stat_w     (stat_w),
  .mask_w     (mask_w),
  .level_o    (level_o)
);

// File: tb/irq_level_ctrl_bench.sv
module irq_level_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0, reg_sel_i = 1'b0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic [31:0] set_i = '0, clr_i = '0;
  logic        cop_set_i = 1'b0, cop_clr_i = 1'b0, cop_hi_sel_i = 1'b0, variant_i = 1'b0;
  logic        timer_top_i = 1'b0;
  logic [2:0]  level_o;
  int          errors = 0, checks = 0;

  localparam logic [31:0] M7 = 32'hC000_0000, M6 = 32'h3C00_0000, M5 = 32'h03C0_0000,
                          M4 = 32'h003F_0000, M3 = 32'h0000_FF00, M2 = 32'h0000_00FC,
                          M1 = 32'h0000_0003;

  always #5ns clk = ~clk;

  irq_level_ctrl u_irq_level_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .set_i(set_i), .clr_i(clr_i),
    .cop_set_i(cop_set_i), .cop_clr_i(cop_clr_i), .cop_hi_sel_i(cop_hi_sel_i),
    .variant_i(variant_i), .timer_top_i(timer_top_i), .level_o(level_o)
  );

  function automatic int ref_lvl(logic [31:0] eff, logic tt);
    if ((eff & M7) != 0) return 7;
    if (tt && eff[29])   return 7;
    if ((eff & M6) != 0) return 6;
    if ((eff & M5) != 0) return 5;
    if ((eff & M4) != 0) return 4;
    if ((eff & M3) != 0) return 3;
    if ((eff & M2) != 0) return 2;
    if ((eff & M1) != 0) return 1;
    return 0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic sel, logic [31:0] d);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    tick();
    reg_we_i = 1'b0;
  endtask

  task automatic read(logic sel, output logic [31:0] v);
    reg_sel_i = sel;
    #1ns;
    v = reg_rdata_o;
  endtask

  task automatic lvl_case(string req, logic [31:0] st, logic [31:0] mk, logic tt);
    timer_top_i = tt;
    wr(1'b0, st);
    wr(1'b1, mk);
    tick();
    check(req, {29'd0, level_o}, ref_lvl(st & mk, tt));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1 during reset
    read(1'b0, v); check("R1", v, 32'h0);
    read(1'b1, v); check("R1", v, 32'h0);
    check("R1", {29'd0, level_o}, 32'd0);
    rst_ni = 1'b1;
    tick();
    check("R1", {29'd0, level_o}, 32'd0);

    // R2 whole-register writes and readback
    wr(1'b0, 32'hA5A5_5A5A); read(1'b0, v); check("R2", v, 32'hA5A5_5A5A);
    wr(1'b1, 32'h0F0F_F0F0); read(1'b1, v); check("R2", v, 32'h0F0F_F0F0);
    read(1'b0, v); check("R10", v, 32'hA5A5_5A5A);
    wr(1'b0, 32'h0); wr(1'b1, 32'h0);

    // R3 set, release, set wins
    set_i = 32'h0000_0300; tick(); set_i = '0;
    read(1'b0, v); check("R3", v, 32'h0000_0300);
    clr_i = 32'h0000_0100; tick(); clr_i = '0;
    read(1'b0, v); check("R3", v, 32'h0000_0200);
    set_i = 32'h4; clr_i = 32'h4; tick(); set_i = '0; clr_i = '0;
    read(1'b0, v); check("R3", v, 32'h0000_0204);
    // R4 masked out -> level 0, R10 still pending
    tick();
    check("R4", {29'd0, level_o}, 32'd0);
    read(1'b0, v); check("R10", v, 32'h0000_0204);

    // R7 register delay: mask write, level one edge later
    wr(1'b1, 32'hFFFF_FFFF);
    check("R7", {29'd0, level_o}, 32'd0);
    tick();
    check("R7", {29'd0, level_o}, 32'd3);

    // R5 single-bit sweep, all unmasked
    for (int b = 0; b < 32; b++) lvl_case("R5", 32'h1 << b, 32'hFFFF_FFFF, 1'b0);
    // R4/R10 mask sweep with full status
    for (int b = 0; b < 32; b++) lvl_case("R4", 32'hFFFF_FFFF, 32'h1 << b, 1'b0);
    lvl_case("R4", 32'hFFFF_FFFF, 32'h0, 1'b1);
    // R5 pairwise priority
    for (int a = 0; a < 32; a++)
      for (int b = a + 1; b < 32; b++)
        lvl_case("R5", (32'h1 << a) | (32'h1 << b), 32'hFFFF_FFFF, 1'b0);
    // R6 timer promotion
    lvl_case("R6", 32'h2000_0000, 32'hFFFF_FFFF, 1'b0);
    lvl_case("R6", 32'h2000_0000, 32'hFFFF_FFFF, 1'b1);
    lvl_case("R6", 32'h2000_0000, 32'hDFFF_FFFF, 1'b1);
    lvl_case("R6", 32'h2400_0000, 32'hFFFF_FFFF, 1'b1);
    for (int b = 0; b < 32; b++) lvl_case("R6", 32'h1 << b, 32'hFFFF_FFFF, 1'b1);
    timer_top_i = 1'b0;

    // R8 coprocessor routing
    wr(1'b0, 32'h0);
    cop_set_i = 1'b1; tick(); cop_set_i = 1'b0;
    read(1'b0, v); check("R8", v, 32'h0000_0100);
    tick(); check("R8", {29'd0, level_o}, 32'd3);
    // R9 move to level 4
    cop_hi_sel_i = 1'b1; tick();
    read(1'b0, v); check("R9", v, 32'h0001_0000);
    tick(); check("R9", {29'd0, level_o}, 32'd4);
    cop_hi_sel_i = 1'b0; tick();
    read(1'b0, v); check("R9", v, 32'h0000_0100);
    cop_clr_i = 1'b1; tick(); cop_clr_i = 1'b0;
    read(1'b0, v); check("R8", v, 32'h0);
    // R9 no pending -> select change raises nothing
    cop_hi_sel_i = 1'b1; tick(); tick();
    read(1'b0, v); check("R9", v, 32'h0);
    cop_hi_sel_i = 1'b0; tick(); tick();
    read(1'b0, v); check("R9", v, 32'h0);
    // R8 strap forces level 4
    variant_i = 1'b1; tick();
    cop_set_i = 1'b1; tick(); cop_set_i = 1'b0;
    read(1'b0, v); check("R8", v, 32'h0001_0000);
    cop_hi_sel_i = 1'b1; tick(); cop_hi_sel_i = 1'b0; tick();
    read(1'b0, v); check("R9", v, 32'h0001_0000);
    tick(); check("R8", {29'd0, level_o}, 32'd4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule